// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block gathers eight interrupt request lines, resolves them with fixed priority (line 0 wins) and signals the processor with a single interrupt output. Software programs it through a byte-wide port with two addresses, a command address and a data address. A short initialization sequence sets the vector base, the cascade arrangement and the end-of-interrupt style. After that, command writes issue end-of-interrupt operations or choose which internal register a command read returns, and data writes load the mask.

When the processor acknowledges, the controller returns an 8-bit vector equal to the base plus the number of the winning line. It also moves that line from pending to in-service. The in-service bit then blocks equal and lower priority lines until it is cleared by an end-of-interrupt command, or at once in automatic mode. Two instances form a cascade. The master drives the number of the line that owns a slave onto the cascade lines, and the slave whose identity matches supplies the vector. If no eligible request is left when the acknowledge arrives, the answer is the vector for line 7 and no in-service bit is set.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the mask register reads 0xFF on the data address, the request and in-service registers are zero, command reads return the request register, and `int_req` is low.
- R2: A command write with bit 4 set starts initialization. In that word, bit 0 requests a fourth word and bit 1 marks a single controller. The next data writes load the vector base, then the cascade word (skipped when bit 1 was set), then the fourth word (only when bit 0 was set). Every later data write loads the mask.
- R3: An acknowledge that this controller answers without cascading makes `vec_vld` high for exactly the following cycle, with `vec_out` equal to the base plus the index of the winning line.
- R4: The winning line is the lowest-numbered pending, unmasked line. `int_req` is high exactly when that line has a lower number than every set in-service bit.
- R5: A request bit is set by a rising edge on its input. It is cleared when the input goes low or when the line is acknowledged.
- R6: Without automatic mode, an acknowledge sets the winner's in-service bit. A command write of 0x60+L clears only in-service bit L. A command write of 0x20 clears the lowest-numbered set in-service bit.
- R7: When bit 1 of the fourth initialization word is 1, an acknowledge leaves the in-service register unchanged.
- R8: A command write of 0x0A makes command reads return the request register, and 0x0B makes them return the in-service register. The choice lasts until the next such write or until initialization.
- R9: A set mask bit stops its line from winning and from raising `int_req`, but the line is still latched into the request register. A mask of 0xFF blocks every line.
- R10: An acknowledge with no eligible line returns base+7 and leaves the in-service register unchanged.
- R11: A master (`role_master` high) that acknowledges a line whose bit is set in its cascade word drives that line number on `cas_out` with `cas_out_vld` high during the acknowledge cycle. It gives no vector, and it sets that in-service bit.
- R12: A slave (`role_master` low) answers an acknowledge only when `cas_in_vld` is high and `cas_in` equals bits 2:0 of its cascade word. Otherwise it raises no `vec_vld` and keeps its request register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| role_master | input | 1 | 1 = master, 0 = slave |
| req_in | input | 8 | Interrupt request lines, line 0 highest |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | 0 = command address, 1 = data address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| int_req | output | 1 | Interrupt request to the processor |
| ack | input | 1 | One-cycle interrupt acknowledge |
| vec_out | output | 8 | Vector returned after acknowledge |
| vec_vld | output | 1 | `vec_out` valid, one cycle after acknowledge |
| cas_in_vld | input | 1 | Slave: cascade selection is valid |
| cas_in | input | 3 | Slave: cascade line number from the master |
| cas_out_vld | output | 1 | Master: cascade selection is being driven |
| cas_out | output | 3 | Master: number of the cascaded line |

## Verification
A stale or corrupted in-service bit shows at the ports in two ways. It holds `int_req` low while a lower-priority request waits, and it changes what the command address returns in in-service selection, one cycle after the acknowledge or command that caused it. A wrong request bit or a wrong priority decision shows up as the wrong vector on the cycle after an acknowledge. A wrong step in the initialization sequence shows up as the wrong base in every later vector, or as a mask read-back that differs from what was written. In a cascade, a wrong identity compare shows as a missing or duplicated `vec_vld` between the two instances in the cycle after the acknowledge.

// File: rtl/pic_pkg.sv
// Package: shared types and command encodings for the priority interrupt controller.
// Assumes an 8-bit register port; encodings are fixed by the programming model.
package pic_pkg;
    typedef enum logic [1:0] {
        SEQ_RDY = 2'd0,
        SEQ_W2  = 2'd1,
        SEQ_W3  = 2'd2,
        SEQ_W4  = 2'd3
    } seq_t;

    localparam logic ADDR_CMD  = 1'b0;
    localparam logic ADDR_DATA = 1'b1;

    localparam int  INIT_BIT      = 4;   // command bit that starts initialization
    localparam int  SELECT_BIT    = 3;   // command bit marking a read-select word
    localparam int  NEED4_BIT     = 0;   // init word 1: fourth word follows
    localparam int  SINGLE_BIT    = 1;   // init word 1: no cascade word
    localparam int  AUTO_EOI_BIT  = 1;   // init word 4: automatic end of interrupt
    localparam logic [2:0] EOI_SPEC_OP = 3'b011;
    localparam logic [2:0] EOI_NS_OP   = 3'b001;
endpackage

// File: rtl/pic_prio_find.sv
// Module: finds the lowest-numbered set bit of a vector (fixed priority, bit 0 wins).
// Assumes N >= 2; purely combinational.
module pic_prio_find #(
    parameter int N  = 8,
    localparam int LW = $clog2(N)
) (
    input  logic [N-1:0]  vec,
    output logic          hit,
    output logic [LW-1:0] idx
);
    // scan from the lowest priority upward so the lowest index is kept last
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                hit = 1'b1;
                idx = LW'(i);
            end
        end
    end
endmodule

// File: rtl/pic_cfg.sv
// Module: register-port decoder. Runs the initialization word sequence, holds the
// mask, base, cascade word, auto-EOI flag and read selection, and emits one-cycle
// end-of-interrupt pulses. Assumes one write per cycle and data width W >= N.
module pic_cfg
    import pic_pkg::*;
#(
    parameter int N  = 8,
    parameter int W  = 8,
    localparam int LW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic          addr,
    input  logic [W-1:0]  wdata,
    output logic [N-1:0]  imr,
    output logic [W-1:0]  base,
    output logic [W-1:0]  casw,
    output logic          aeoi,
    output logic          rd_isr,
    output logic          init_clr,
    output logic          eoi_spec,
    output logic          eoi_ns,
    output logic [LW-1:0] eoi_lvl
);
    seq_t state;
    logic need4, single;

    logic cmd_wr, data_wr;
    assign cmd_wr  = wr && (addr == ADDR_CMD);
    assign data_wr = wr && (addr == ADDR_DATA);

    // decode the command-address pulses
    always_comb begin
        init_clr = cmd_wr && wdata[INIT_BIT];
        eoi_spec = cmd_wr && !wdata[INIT_BIT] && !wdata[SELECT_BIT] && (wdata[7:5] == EOI_SPEC_OP);
        eoi_ns   = cmd_wr && !wdata[INIT_BIT] && !wdata[SELECT_BIT] && (wdata[7:5] == EOI_NS_OP);
        eoi_lvl  = wdata[LW-1:0];
    end

    // initialization sequencer and configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= SEQ_RDY;
            need4  <= 1'b0;
            single <= 1'b0;
            imr    <= '1;
            base   <= '0;
            casw   <= '0;
            aeoi   <= 1'b0;
            rd_isr <= 1'b0;
        end else if (init_clr) begin
            state  <= SEQ_W2;
            need4  <= wdata[NEED4_BIT];
            single <= wdata[SINGLE_BIT];
            casw   <= '0;
            aeoi   <= 1'b0;
            rd_isr <= 1'b0;
        end else if (cmd_wr && wdata[SELECT_BIT] && wdata[1]) begin
            rd_isr <= wdata[0];
        end else if (data_wr) begin
            unique case (state)
                SEQ_W2: begin
                    base  <= wdata;
                    state <= single ? (need4 ? SEQ_W4 : SEQ_RDY) : SEQ_W3;
                end
                SEQ_W3: begin
                    casw  <= wdata;
                    state <= need4 ? SEQ_W4 : SEQ_RDY;
                end
                SEQ_W4: begin
                    aeoi  <= wdata[AUTO_EOI_BIT];
                    state <= SEQ_RDY;
                end
                default: imr <= wdata[N-1:0];
            endcase
        end
    end

    // R2
    init_starts_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_clr |=> (state == SEQ_W2));
    // R9
    mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && state == SEQ_RDY && !init_clr) |=> (imr == $past(wdata[N-1:0])));
endmodule

// File: rtl/prio_irq_ctrl.sv
// Module: eight-input priority interrupt controller top. Latches edge requests,
// resolves fixed priority against in-service levels, answers acknowledges with a
// vector or a cascade selection, and serves end-of-interrupt commands.
// Assumes a one-cycle ack pulse; in a cascade the master's cas_out feeds the
// slave's cas_in within the same cycle.
module prio_irq_ctrl
    import pic_pkg::*;
#(
    parameter int N  = 8,
    parameter int W  = 8,
    localparam int LW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          role_master,
    input  logic [N-1:0]  req_in,
    input  logic          bus_wr,
    input  logic          bus_addr,
    input  logic [W-1:0]  bus_wdata,
    output logic [W-1:0]  bus_rdata,
    output logic          int_req,
    input  logic          ack,
    output logic [W-1:0]  vec_out,
    output logic          vec_vld,
    input  logic          cas_in_vld,
    input  logic [LW-1:0] cas_in,
    output logic          cas_out_vld,
    output logic [LW-1:0] cas_out
);
    logic [N-1:0]  imr;
    logic [W-1:0]  base, casw;
    logic          aeoi, rd_isr, init_clr, eoi_spec, eoi_ns;
    logic [LW-1:0] eoi_lvl;

    pic_cfg #(.N(N), .W(W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
        .imr(imr), .base(base), .casw(casw), .aeoi(aeoi), .rd_isr(rd_isr),
        .init_clr(init_clr), .eoi_spec(eoi_spec), .eoi_ns(eoi_ns), .eoi_lvl(eoi_lvl)
    );

    logic [N-1:0]  irr_q, isr_q, req_prev;
    logic          req_hit, isr_hit;
    logic [LW-1:0] req_idx, isr_idx;

    pic_prio_find #(.N(N)) u_req_find (.vec(irr_q & ~imr), .hit(req_hit), .idx(req_idx));
    pic_prio_find #(.N(N)) u_isr_find (.vec(isr_q),         .hit(isr_hit), .idx(isr_idx));

    logic eligible, selected, cascaded, ack_take;
    logic [N-1:0] take_mask, set_mask, clr_mask;

    // acknowledge decision and cascade selection
    always_comb begin
        eligible  = req_hit && (!isr_hit || (req_idx < isr_idx));
        selected  = ack && (role_master || (cas_in_vld && (cas_in == casw[LW-1:0])));
        cascaded  = role_master && eligible && casw[req_idx];
        ack_take  = selected && eligible;
        take_mask = ack_take ? (N'(1) << req_idx) : '0;
        set_mask  = aeoi ? '0 : take_mask;
        clr_mask  = (eoi_spec ? (N'(1) << eoi_lvl) : '0)
                  | ((eoi_ns && isr_hit) ? (N'(1) << isr_idx) : '0);
    end

    assign int_req     = eligible;
    assign cas_out_vld = ack && cascaded;
    assign cas_out     = cas_out_vld ? req_idx : '0;
    assign bus_rdata   = (bus_addr == ADDR_DATA) ? W'(imr) : (rd_isr ? W'(isr_q) : W'(irr_q));

    // request, in-service and vector registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irr_q    <= '0;
            isr_q    <= '0;
            req_prev <= '0;
            vec_out  <= '0;
            vec_vld  <= 1'b0;
        end else begin
            req_prev <= req_in;
            vec_vld  <= selected && !cascaded;
            if (selected && !cascaded)
                vec_out <= eligible ? (base + W'(req_idx)) : (base + W'(N - 1));
            if (init_clr) begin
                irr_q <= '0;
                isr_q <= '0;
            end else begin
                irr_q <= ((irr_q | (req_in & ~req_prev)) & req_in) & ~take_mask;
                isr_q <= (isr_q & ~clr_mask) | set_mask;
            end
        end
    end

    // R3
    vec_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_vld |-> $past(ack));
    // R4
    int_needs_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_req |-> ((irr_q & ~imr) != '0));
    // R6
    spec_eoi_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_spec && !ack && !init_clr) |=> !isr_q[$past(eoi_lvl)]);
    // R7
    auto_eoi_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (aeoi && ack) |=> ((isr_q & ~$past(isr_q)) == '0));
    // R10
    spurious_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (selected && !eligible) |=> ((isr_q & ~$past(isr_q)) == '0));
    // R11
    cascade_no_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cas_out_vld |=> !vec_vld);
endmodule

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;
    localparam int PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(PERIOD / 2) clk = ~clk;

    logic [7:0] mreq = '0, sreq = '0;
    logic       m_wr = 1'b0, s_wr = 1'b0, bus_addr = 1'b0, ack = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] m_rdata, s_rdata, m_vec, s_vec, m_req_in;
    logic       m_int, s_int, m_vld, s_vld, m_cvld, s_cvld_unused;
    logic [2:0] m_cas, s_cas_unused;

    assign m_req_in = {mreq[7:3], mreq[2] | s_int, mreq[1:0]};

    prio_irq_ctrl i_prio_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .role_master(1'b1), .req_in(m_req_in),
        .bus_wr(m_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(m_rdata),
        .int_req(m_int), .ack(ack), .vec_out(m_vec), .vec_vld(m_vld),
        .cas_in_vld(1'b0), .cas_in(3'd0), .cas_out_vld(m_cvld), .cas_out(m_cas)
    );

    prio_irq_ctrl i_prio_irq_ctrl_slv (
        .clk(clk), .rst_n(rst_n), .role_master(1'b0), .req_in(sreq),
        .bus_wr(s_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(s_rdata),
        .int_req(s_int), .ack(ack), .vec_out(s_vec), .vec_vld(s_vld),
        .cas_in_vld(m_cvld), .cas_in(m_cas), .cas_out_vld(s_cvld_unused), .cas_out(s_cas_unused)
    );

    int checks = 0, fails = 0;
    bit done = 1'b0;

    task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%02h expected 0x%02h", req, what, act, exp);
        end
    endtask

    task automatic wr(input bit slv, input logic a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d;
        if (slv) s_wr = 1'b1; else m_wr = 1'b1;
        @(negedge clk);
        m_wr = 1'b0; s_wr = 1'b0;
    endtask

    task automatic rd(input bit slv, input logic a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = slv ? s_rdata : m_rdata;
    endtask

    task automatic setreq(input logic [7:0] m, input logic [7:0] s);
        @(negedge clk);
        mreq = m; sreq = s;
        @(negedge clk);
        @(negedge clk);
    endtask

    logic [7:0] a_vec;
    logic       a_mv, a_sv, a_cv;
    logic [2:0] a_co;

    task automatic do_ack();
        @(negedge clk);
        ack = 1'b1;
        #1;
        a_cv = m_cvld; a_co = m_cas;
        @(negedge clk);
        ack = 1'b0;
        a_mv = m_vld; a_sv = s_vld;
        a_vec = m_vld ? m_vec : s_vec;
    endtask

    logic [7:0] r;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(0, 1, r); check("R1", "mask after reset", r, 8'hFF);
        rd(0, 0, r); check("R1", "request after reset", r, 8'h00);
        check("R1", "int after reset", {7'd0, m_int}, 8'h00);

        // R2 single controller: base, word 4, then mask
        wr(0, 0, 8'h13); wr(0, 1, 8'h40); wr(0, 1, 8'h01); wr(0, 1, 8'h00);
        rd(0, 1, r); check("R2", "mask loaded after sequence", r, 8'h00);

        // R3 R5 R6: every line alone
        for (int n = 0; n < 8; n++) begin
            setreq(8'(1 << n), 8'h00);
            wr(0, 0, 8'h0A);
            rd(0, 0, r); check("R5", "request latched", r, 8'(1 << n));
            check("R4", "int with one request", {7'd0, m_int}, 8'h01);
            do_ack();
            check("R3", "vector base+n", a_vec, 8'(8'h40 + n));
            check("R3", "vector valid", {7'd0, a_mv}, 8'h01);
            rd(0, 0, r); check("R5", "request cleared by ack", r, 8'h00);
            wr(0, 0, 8'h0B);
            rd(0, 0, r); check("R6", "in-service set", r, 8'(1 << n));
            wr(0, 0, 8'(8'h60 + n));
            rd(0, 0, r); check("R6", "specific eoi clears", r, 8'h00);
            setreq(8'h00, 8'h00);
        end

        // R4 all pairs, non-specific EOI
        for (int i = 0; i < 8; i++) begin
            for (int j = i + 1; j < 8; j++) begin
                setreq(8'((1 << i) | (1 << j)), 8'h00);
                do_ack();
                check("R4", "higher priority wins", a_vec, 8'(8'h40 + i));
                check("R4", "lower blocked by in-service", {7'd0, m_int}, 8'h00);
                wr(0, 0, 8'h20);
                check("R6", "int back after eoi", {7'd0, m_int}, 8'h01);
                do_ack();
                check("R4", "second line served", a_vec, 8'(8'h40 + j));
                wr(0, 0, 8'h20);
                rd(0, 0, r); check("R6", "non-specific eoi empties", r, 8'h00);
                setreq(8'h00, 8'h00);
            end
        end

        // R6 nesting: specific EOI touches only its level; R8 select persists
        setreq(8'h10, 8'h00); do_ack();
        setreq(8'h12, 8'h00);
        check("R4", "higher line preempts", {7'd0, m_int}, 8'h01);
        do_ack(); check("R4", "nested vector", a_vec, 8'h41);
        rd(0, 0, r); check("R8", "isr select persists", r, 8'h12);
        wr(0, 0, 8'h64);
        rd(0, 0, r); check("R6", "only level 4 cleared", r, 8'h02);
        wr(0, 0, 8'h20);
        rd(0, 0, r); check("R6", "lowest set bit cleared", r, 8'h00);
        setreq(8'h00, 8'h00);

        // R9 mask
        wr(0, 1, 8'hFF);
        setreq(8'h08, 8'h00);
        check("R9", "masked line no int", {7'd0, m_int}, 8'h00);
        wr(0, 0, 8'h0A);
        rd(0, 0, r); check("R9", "masked line still latched", r, 8'h08);
        do_ack(); check("R9", "masked ack gives base+7", a_vec, 8'h47);
        wr(0, 0, 8'h0B);
        rd(0, 0, r); check("R10", "no in-service on spurious", r, 8'h00);
        wr(0, 1, 8'hF7);
        check("R9", "unmasked line raises int", {7'd0, m_int}, 8'h01);
        do_ack(); check("R9", "unmasked vector", a_vec, 8'h43);
        wr(0, 0, 8'h63); wr(0, 1, 8'h00);
        setreq(8'h00, 8'h00);

        // R10 request withdrawn before ack
        setreq(8'h20, 8'h00);
        setreq(8'h00, 8'h00);
        wr(0, 0, 8'h0A);
        rd(0, 0, r); check("R5", "request dropped with input", r, 8'h00);
        do_ack();
        check("R10", "spurious vector", a_vec, 8'h47);
        check("R10", "spurious valid", {7'd0, a_mv}, 8'h01);
        wr(0, 0, 8'h0B);
        rd(0, 0, r); check("R10", "spurious leaves isr", r, 8'h00);

        // R7 auto-EOI
        wr(0, 0, 8'h13); wr(0, 1, 8'h40); wr(0, 1, 8'h03); wr(0, 1, 8'h00);
        rd(0, 0, r); check("R8", "init resets select to request", r, 8'h00);
        wr(0, 0, 8'h0B);
        for (int n = 0; n < 8; n++) begin
            setreq(8'(1 << n), 8'h00);
            do_ack();
            check("R7", "auto vector", a_vec, 8'(8'h40 + n));
            rd(0, 0, r); check("R7", "auto eoi isr empty", r, 8'h00);
            setreq(8'h00, 8'h00);
        end

        // R11 R12 cascade
        wr(0, 0, 8'h11); wr(0, 1, 8'h20); wr(0, 1, 8'h04); wr(0, 1, 8'h01); wr(0, 1, 8'h00);
        wr(1, 0, 8'h11); wr(1, 1, 8'h70); wr(1, 1, 8'h02); wr(1, 1, 8'h01); wr(1, 1, 8'h00);
        wr(0, 0, 8'h0B);
        for (int k = 0; k < 8; k++) begin
            setreq(8'h00, 8'(1 << k));
            check("R11", "master int from slave", {7'd0, m_int}, 8'h01);
            do_ack();
            check("R11", "cascade valid", {7'd0, a_cv}, 8'h01);
            check("R11", "cascade line", {5'd0, a_co}, 8'h02);
            check("R11", "master gives no vector", {7'd0, a_mv}, 8'h00);
            check("R12", "slave answers", {7'd0, a_sv}, 8'h01);
            check("R12", "slave vector", a_vec, 8'(8'h70 + k));
            rd(0, 0, r); check("R11", "master isr line 2", r, 8'h04);
            wr(1, 0, 8'(8'h60 + k)); wr(0, 0, 8'h62);
            setreq(8'h00, 8'h00);
        end
        setreq(8'h20, 8'h00);
        do_ack();
        check("R12", "slave silent without cascade", {7'd0, a_sv}, 8'h00);
        check("R3", "master direct vector", a_vec, 8'h25);
        wr(0, 0, 8'h20);
        setreq(8'h00, 8'h00);

        // R12 identity mismatch
        wr(1, 0, 8'h11); wr(1, 1, 8'h70); wr(1, 1, 8'h03); wr(1, 1, 8'h01); wr(1, 1, 8'h00);
        setreq(8'h00, 8'h01);
        do_ack();
        check("R11", "cascade still driven", {7'd0, a_cv}, 8'h01);
        check("R12", "mismatched slave silent", {7'd0, a_sv}, 8'h00);
        check("R12", "no vector at all", {7'd0, a_mv}, 8'h00);
        rd(1, 0, r); check("R12", "slave request kept", r, 8'h01);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule